// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block answers one question for an interrupt controller: among the interrupt sources that are both pending and enabled right now, which one has the best rank in the FIQ class, and which one has the best rank in the IRQ class? Rank does not come from the source number. It comes from a programmable table of ranked slots, where each slot names one source. Slot 0 holds the best rank. The two winners are packed into opposite halves of a single 32-bit status word, and each half carries its own valid flag.

The caller supplies four inputs: the per-source active vector (pending and enabled already combined), the per-source class-steering vector, and the slot table, which gives an enable flag and a 6-bit source ID for each slot. The caller then pulses `start_i`. The block captures a snapshot of all inputs and walks the table a fixed number of slots per cycle. When the walk ends, it raises `done_o` for one cycle. The status word stays unchanged until the next completed scan. Register storage, bus decode and the generation of the interrupt lines belong to the surrounding controller.

Top module: `pri_resolver`

## Requirements
- R1: After reset, `word_o` reads 0x003F003F and both `busy_o` and `done_o` are low.
- R2: Within one class, the candidate in the lowest-numbered slot wins, whatever its source number. When one source ID appears in several slots, the earliest of those slots is the one that counts.
- R3: A slot takes no part in the scan if its enable flag is 0, or if its source ID is NUM_SRC (40) or larger.
- R4: A slot's source is a candidate only when its bit in `act_i` is 1. If its `fiq_sel_i` bit is 1 it competes for the FIQ result; if that bit is 0 it competes for the IRQ result.
- R5: The FIQ result sits in the low half-word. Bit 15 is its valid flag and bits 5:0 hold the winning source ID.
- R6: The IRQ result sits in the high half-word. Bit 31 is its valid flag and bits 21:16 hold the winning source ID.
- R7: A class with no candidate shows valid = 0 and ID = 0x3F in its half. With no candidates in either class, the word is 0x003F003F.
- R8: Bits 30:22 and 14:6 of `word_o` are always 0.
- R9: The FIQ and IRQ halves are resolved independently, so both can be valid in the same word.
- R10: If `start_i` is high at a rising edge while the block is idle, `done_o` goes high for exactly one cycle after the NCH-th following edge. NCH = ceil(NUM_SLOT/LANES), which is 5 by default. `busy_o` is high from the start edge until `done_o` rises.
- R11: Inputs are sampled only at the start edge. While `busy_o` is high, changes on the inputs and further `start_i` pulses have no effect on the result and do not trigger another scan.
- R12: `word_o` changes only in the cycle in which `done_o` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a scan when the block is idle |
| act_i | input | NUM_SRC | Per-source pending-and-enabled bits |
| fiq_sel_i | input | NUM_SRC | Per-source class: 1 = FIQ, 0 = IRQ |
| slot_en_i | input | NUM_SLOT | Per-slot enable flag |
| slot_src_i | input | NUM_SLOT*6 | Per-slot source ID; slot k uses bits 6k+5:6k |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when a new result is in `word_o` |
| word_o | output | 32 | Packed FIQ and IRQ winners |

## Verification
The hardest case to reach from the ports is a rank decided by the slot order when that order disagrees with the source numbers. A second hard case is a winner that sits in a late lane group after earlier groups held only candidates of the other class. The stimulus reaches both by putting every pair of slots against each other with descending source IDs. It also places single entries at every slot position, so each lane of each group is exercised, and it adds long runs of random tables that include out-of-range IDs and duplicated IDs. Sampling is tested by changing every input and pulsing start again in the middle of a scan.

// File: rtl/pri_res_pkg.sv
package pri_res_pkg;

    localparam int ID_W   = 6;
    localparam int WORD_W = 32;
    localparam logic [ID_W-1:0] ID_NONE = '1;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
    } win_t;

    // Places both class results into the status word; reserved bits stay zero.
    function automatic logic [WORD_W-1:0] pack_word(
        input logic            fiq_v,
        input logic [ID_W-1:0] fiq_id,
        input logic            irq_v,
        input logic [ID_W-1:0] irq_id
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31]    = irq_v;
        w[21:16] = irq_v ? irq_id : ID_NONE;
        w[15]    = fiq_v;
        w[5:0]   = fiq_v ? fiq_id : ID_NONE;
        return w;
    endfunction

endpackage

// File: rtl/pri_slot_eval.sv
module pri_slot_eval
    import pri_res_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               en_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic [NUM_SRC-1:0] act_i,
    input  logic [NUM_SRC-1:0] fiq_sel_i,
    output logic               fiq_hit_o,
    output logic               irq_hit_o
);
    localparam int SPAN = 1 << ID_W;

    logic [SPAN-1:0] act_pad;
    logic [SPAN-1:0] sel_pad;
    logic            in_range;
    logic            live;

    assign act_pad  = SPAN'(act_i);
    assign sel_pad  = SPAN'(fiq_sel_i);
    assign in_range = ({1'b0, id_i} < (ID_W + 1)'(NUM_SRC));
    assign live     = en_i & in_range & act_pad[id_i];

    assign fiq_hit_o = live &  sel_pad[id_i];
    assign irq_hit_o = live & ~sel_pad[id_i];

endmodule

// File: rtl/pri_chunk_pick.sv
module pri_chunk_pick
    import pri_res_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0]      fiq_hit_i,
    input  logic [LANES-1:0]      irq_hit_i,
    input  logic [LANES*ID_W-1:0] ids_i,
    output win_t                  fiq_win_o,
    output win_t                  irq_win_o
);
    // Walk from the last lane down so that the lowest lane overwrites last.
    always_comb begin
        fiq_win_o = '0;
        irq_win_o = '0;
        for (int j = LANES - 1; j >= 0; j--) begin
            if (fiq_hit_i[j]) begin
                fiq_win_o.hit = 1'b1;
                fiq_win_o.id  = ids_i[j*ID_W +: ID_W];
            end
            if (irq_hit_i[j]) begin
                irq_win_o.hit = 1'b1;
                irq_win_o.id  = ids_i[j*ID_W +: ID_W];
            end
        end
    end

endmodule

// File: rtl/pri_resolver.sv
module pri_resolver
    import pri_res_pkg::*;
#(
    parameter int NUM_SRC  = 40,
    parameter int NUM_SLOT = 40,
    parameter int LANES    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_SRC-1:0]       act_i,
    input  logic [NUM_SRC-1:0]       fiq_sel_i,
    input  logic [NUM_SLOT-1:0]      slot_en_i,
    input  logic [NUM_SLOT*ID_W-1:0] slot_src_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [WORD_W-1:0]        word_o
);
    localparam int NCH       = (NUM_SLOT + LANES - 1) / LANES;
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PAD_SLOTS = NCH * LANES;

    typedef struct packed {
        logic                      busy;
        logic                      done;
        logic [CH_W-1:0]           chunk;
        logic [NUM_SRC-1:0]        act;
        logic [NUM_SRC-1:0]        sel;
        logic [PAD_SLOTS-1:0]      en;
        logic [PAD_SLOTS*ID_W-1:0] ids;
        win_t                      fiq;
        win_t                      irq;
        logic [WORD_W-1:0]         word;
    } st_t;

    st_t st_d, st_q;

    logic [LANES-1:0]      lane_en;
    logic [LANES*ID_W-1:0] lane_ids;
    logic [LANES-1:0]      lane_fiq;
    logic [LANES-1:0]      lane_irq;
    win_t                  fiq_w;
    win_t                  irq_w;

    assign lane_en  = LANES'(st_q.en >> (int'(st_q.chunk) * LANES));
    assign lane_ids = (LANES*ID_W)'(st_q.ids >> (int'(st_q.chunk) * LANES * ID_W));

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        pri_slot_eval #(.NUM_SRC(NUM_SRC)) u_eval (
            .en_i      (lane_en[j]),
            .id_i      (lane_ids[j*ID_W +: ID_W]),
            .act_i     (st_q.act),
            .fiq_sel_i (st_q.sel),
            .fiq_hit_o (lane_fiq[j]),
            .irq_hit_o (lane_irq[j])
        );
    end

    pri_chunk_pick #(.LANES(LANES)) u_pick (
        .fiq_hit_i (lane_fiq),
        .irq_hit_i (lane_irq),
        .ids_i     (lane_ids),
        .fiq_win_o (fiq_w),
        .irq_win_o (irq_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.chunk = '0;
                st_d.act   = act_i;
                st_d.sel   = fiq_sel_i;
                st_d.en    = PAD_SLOTS'(slot_en_i);
                st_d.ids   = (PAD_SLOTS*ID_W)'(slot_src_i);
                st_d.fiq   = '0;
                st_d.irq   = '0;
            end
        end else begin
            if (!st_q.fiq.hit && fiq_w.hit) st_d.fiq = fiq_w;
            if (!st_q.irq.hit && irq_w.hit) st_d.irq = irq_w;
            if (st_q.chunk == CH_W'(NCH - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.word = pack_word(st_d.fiq.hit, st_d.fiq.id,
                                      st_d.irq.hit, st_d.irq.id);
            end else begin
                st_d.chunk = st_q.chunk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.word <= pack_word(1'b0, '0, 1'b0, '0);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign word_o = st_q.word;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R12
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> done_o);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o[30:22] == '0) && (word_o[14:6] == '0));

    // R7
    fiq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_o[15] |-> (word_o[5:0] == ID_NONE));

    // R7
    irq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_o[31] |-> (word_o[21:16] == ID_NONE));

endmodule

// File: tb/tb_pri_resolver.sv
module tb_pri_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 40;
    localparam int NSLOT = 40;
    localparam int LANES = 8;
    localparam int NCH   = (NSLOT + LANES - 1) / LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NSRC-1:0]   act = '0;
    logic [NSRC-1:0]   sel = '0;
    logic [NSLOT-1:0]  en = '0;
    logic [5:0]        ids [NSLOT];
    logic [NSLOT*6-1:0] ids_flat;
    logic              busy, done;
    logic [31:0]       word;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) ids_flat[i*6 +: 6] = ids[i];
    end

    pri_resolver #(.NUM_SRC(NSRC), .NUM_SLOT(NSLOT), .LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .act_i(act),
        .fiq_sel_i(sel), .slot_en_i(en), .slot_src_i(ids_flat),
        .busy_o(busy), .done_o(done), .word_o(word)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    function automatic logic [31:0] model();
        bit fv = 0;
        bit iv = 0;
        logic [5:0] fid = 6'h3F;
        logic [5:0] iid = 6'h3F;
        for (int i = 0; i < NSLOT; i++) begin
            if (en[i] && ids[i] < NSRC) begin
                if (act[ids[i]]) begin
                    if (sel[ids[i]]) begin
                        if (!fv) begin fv = 1; fid = ids[i]; end
                    end else begin
                        if (!iv) begin iv = 1; iid = ids[i]; end
                    end
                end
            end
        end
        return {iv, 9'b0, iid, fv, 9'b0, fid};
    endfunction

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run(input string tag);
        logic [31:0] exp;
        logic [31:0] held;
        int lat;
        exp = model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == NCH, "R10 latency", lat, NCH);
        chk(word == exp, tag, word, exp);
        chk(word[30:22] == 0 && word[14:6] == 0, "R8 reserved", word, exp);
        held = word;
        @(negedge clk);
        chk(!done && word == held, "R12 hold", word, held);
    endtask

    task automatic identity_table();
        for (int i = 0; i < NSLOT; i++) begin ids[i] = 6'(i); en[i] = 1'b1; end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        finish_up();
    end

    initial begin
        identity_table();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(word == 32'h003F003F && !busy && !done, "R1 reset", word, 32'h003F003F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word == 32'h003F003F && !busy && !done, "R1 after release", word, 32'h003F003F);

        // R7 nothing active
        act = '0; run("R7 empty");
        chk(word == 32'h003F003F, "R7 empty word", word, 32'h003F003F);

        // R4 R5 R6 single source sweep in both classes
        for (int s = 0; s < NSRC; s++) begin
            for (int c = 0; c < 2; c++) begin
                act = '0; act[s] = 1'b1; sel = '0; sel[s] = c[0];
                run("R4 single source");
                if (c == 1)
                    chk(word == {16'h003F, 1'b1, 9'b0, 6'(s)}, "R5 fiq half", word,
                        {16'h003F, 1'b1, 9'b0, 6'(s)});
                else
                    chk(word == {1'b1, 9'b0, 6'(s), 16'h003F}, "R6 irq half", word,
                        {1'b1, 9'b0, 6'(s), 16'h003F});
            end
        end

        // R2 reversed table, all active as IRQ: slot 0 names source 39
        for (int i = 0; i < NSLOT; i++) ids[i] = 6'(NSLOT - 1 - i);
        act = '1; sel = '0;
        run("R2 reversed");
        chk(word == 32'h8027003F, "R2 reversed word", word, 32'h8027003F);

        // R2 every slot pair, descending IDs, same class
        for (int p = 0; p < NSLOT; p++) begin
            for (int q = p + 1; q < NSLOT; q++) begin
                en = '0; en[p] = 1'b1; en[q] = 1'b1;
                sel = (p % 2 == 0) ? '1 : '0;
                run("R2 slot pair");
            end
        end

        // R2 every slot position on its own
        for (int p = 0; p < NSLOT; p++) begin
            en = '0; en[p] = 1'b1; ids[p] = 6'd7; sel = '0;
            run("R2 slot position");
            ids[p] = 6'(NSLOT - 1 - p);
        end

        // R3 all flags clear
        identity_table(); en = '0; act = '1;
        run("R3 flags clear");
        chk(word == 32'h003F003F, "R3 flags clear word", word, 32'h003F003F);

        // R3 IDs out of range
        for (int i = 0; i < NSLOT; i++) begin ids[i] = 6'(NSRC + (i % (64 - NSRC))); en[i] = 1'b1; end
        run("R3 out of range");
        chk(word == 32'h003F003F, "R3 range word", word, 32'h003F003F);
        ids[1] = 6'd3; sel = '0;
        run("R3 skip to slot 1");
        chk(word == 32'h8003003F, "R3 slot 1 wins", word, 32'h8003003F);

        // R9 both classes valid, R2 duplicates
        identity_table(); act = '0; act[12] = 1; act[20] = 1; sel = '0; sel[20] = 1;
        ids[5] = 6'd20; ids[9] = 6'd12; ids[30] = 6'd20;
        run("R9 both valid");
        chk(word == 32'h800C8014, "R9 both word", word, 32'h800C8014);

        // R11 mid-scan changes and start pulse ignored
        identity_table(); act = 40'h00_0000_0300; sel = 40'h00_0000_0100;
        begin
            logic [31:0] exp_a;
            int lat;
            bit extra;
            exp_a = model();
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b1; act = '1; sel = '0; en = '1;
            @(negedge clk); start = 1'b0; lat = 1;
            while (!done && lat < 100) begin @(negedge clk); lat++; end
            chk(lat == NCH, "R11 latency", lat, NCH);
            chk(word == exp_a, "R11 snapshot", word, exp_a);
            extra = 0;
            for (int k = 0; k < NCH + 2; k++) begin @(negedge clk); if (done) extra = 1; end
            chk(!extra && word == exp_a, "R11 no restart", word, exp_a);
        end

        // random tables, IDs over the full 6-bit range
        for (int r = 0; r < 1500; r++) begin
            act = {$urandom, $urandom} & {$urandom, $urandom};
            sel = {$urandom, $urandom};
            en  = {$urandom, $urandom} | {$urandom, $urandom};
            for (int i = 0; i < NSLOT; i++) ids[i] = 6'($urandom % 48);
            run("R2 R3 R4 R9 random");
        end

        finish_up();
    end
endmodule